// File: doc/BRIEF.md
# Display Mode Register File

This block holds the mode registers of a graphics adapter: resolution, colour depth, enable flags, bank select, virtual size and pan offsets. Each register is a 16-bit word. A host reaches them through two I/O addresses. It writes a register number to the index address, then reads or writes the selected word through the data address. Reads are combinational from the current address and the stored index.

Every data write is checked before it is stored. An illegal write leaves the register as it was and raises a one-cycle error pulse. When the mode switches on, the block loads the virtual width from the horizontal resolution. It then derives the virtual height from the video memory size, the virtual width and the bytes per pixel. The block also issues one-cycle requests to clear video memory and to refresh the whole screen. It exports the mode, linear-buffer and 8-bit DAC flags as levels.

Top module: `disp_regfile`

## Requirements
- R1: A write to address 0x01CE stores the index, and a read of 0x01CE returns it. Reads and writes at 0x01CF reach the register that the index selects: 0 version, 1 horizontal resolution, 2 vertical resolution, 3 depth, 4 enable, 5 bank, 6 virtual width, 7 virtual height, 8 X pan, 9 Y pan. After reset the version reads 0xB0C4 and every other register reads 0.
- R2: A version write from 0xB0C0 to 0xB0C4 is stored. Any other value is ignored and raises the error pulse.
- R3: While enable bit 0 is set, writes to horizontal resolution, vertical resolution or depth are ignored and raise the error pulse.
- R4: A horizontal resolution above 1024 or a vertical resolution above 768 is rejected with the error pulse. Values up to and including those limits are stored.
- R5: A depth write of 0 is stored as 8. The values 8, 15, 16, 24 and 32 are stored. Any other value is rejected with the error pulse and the depth keeps its old value.
- R6: A write that moves enable bit 0 from 0 to 1 with bit 7 clear raises clr_req for exactly one cycle. With bit 7 set, no clear request is raised. Enable bit 6 drives lfb_en, bit 5 drives dac8_en and bit 0 drives mode_en.
- R7: When enable bit 0 rises, the virtual width takes the horizontal resolution. The virtual height becomes floor(8388608 / (width × bytes per pixel)), with 1 byte for 8 bpp, 2 for 15 and 16 bpp, 3 for 24 bpp and 4 for 32 bpp. It saturates at 0xFFFF, and a zero product also gives 0xFFFF.
- R8: A virtual width write while enabled stores the width and recomputes the virtual height by the R7 formula. While disabled it stores the width only. Writes to the virtual height are ignored and raise no error.
- R9: While enable bit 1 is set, reads of horizontal resolution, vertical resolution and depth return 1024, 768 and 32.
- R10: A write to X pan or Y pan stores the value and raises refresh_req for exactly one cycle. Bank writes are stored and raise no refresh.
- R11: The error pulse lasts one cycle and appears only after a rejected data write. Data writes with an index of 10 or more are ignored without error, and reads at such an index return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one access per cycle |
| io_wdata | input | 16 | Host write data |
| io_rdata | output | 16 | Read data for the current address, combinational |
| err_pulse | output | 1 | One-cycle pulse after a rejected write |
| clr_req | output | 1 | One-cycle video memory clear request |
| refresh_req | output | 1 | One-cycle full-screen refresh request |
| mode_en | output | 1 | Enable bit 0 |
| lfb_en | output | 1 | Linear frame buffer flag |
| dac8_en | output | 1 | 8-bit DAC flag |

## Verification
Read data is combinational. It is due in the same cycle that the address and index are presented, so the bench samples it a short delay after setting the address. A write is taken at a rising edge. The register and the three pulses change at that edge, so the bench samples the pulses at the falling edge that follows, and again one cycle later to confirm that they have dropped. The virtual height is written at the same edge as the enable or width write, so the bench reads it back on the next access. The bench computes each expected height by integer division.

// File: rtl/disp_regfile_pkg.sv
package disp_regfile_pkg;

    typedef enum logic [3:0] {
        RI_ID   = 4'd0,
        RI_XRES = 4'd1,
        RI_YRES = 4'd2,
        RI_BPP  = 4'd3,
        RI_ENA  = 4'd4,
        RI_BANK = 4'd5,
        RI_VW   = 4'd6,
        RI_VH   = 4'd7,
        RI_XOFF = 4'd8,
        RI_YOFF = 4'd9
    } reg_idx_e;

    localparam int EN_BIT   = 0;
    localparam int CAPS_BIT = 1;
    localparam int DAC_BIT  = 5;
    localparam int LFB_BIT  = 6;
    localparam int KEEP_BIT = 7;

    typedef struct packed {
        logic [15:0] idx;
        logic [15:0] id;
        logic [15:0] xres;
        logic [15:0] yres;
        logic [15:0] bpp;
        logic [15:0] ena;
        logic [15:0] bank;
        logic [15:0] vw;
        logic [15:0] vh;
        logic [15:0] xoff;
        logic [15:0] yoff;
        logic        err;
        logic        clr;
        logic        refr;
    } regs_t;

    function automatic logic [2:0] bytes_pp(input logic [15:0] bpp);
        case (bpp)
            16'd8:          bytes_pp = 3'd1;
            16'd15, 16'd16: bytes_pp = 3'd2;
            16'd24:         bytes_pp = 3'd3;
            16'd32:         bytes_pp = 3'd4;
            default:        bytes_pp = 3'd0;
        endcase
    endfunction

    function automatic logic is_legal_bpp(input logic [15:0] bpp);
        is_legal_bpp = (bytes_pp(bpp) != 3'd0);
    endfunction

endpackage

// File: rtl/disp_wcheck.sv
module disp_wcheck
    import disp_regfile_pkg::*;
#(
    parameter logic [15:0] MAX_X = 16'd1024,
    parameter logic [15:0] MAX_Y = 16'd768,
    parameter logic [15:0] ID_LO = 16'hB0C0,
    parameter logic [15:0] ID_HI = 16'hB0C4
) (
    input  logic [15:0] sel,
    input  logic [15:0] wdata,
    input  logic        locked,
    output logic        ok,
    output logic        bad,
    output logic [15:0] norm
);
    always_comb begin
        ok   = 1'b0;
        bad  = 1'b0;
        norm = wdata;
        case (sel)
            16'(RI_ID): begin
                ok  = (wdata >= ID_LO) && (wdata <= ID_HI);
                bad = !ok;
            end
            16'(RI_XRES): begin
                bad = locked || (wdata > MAX_X);
                ok  = !bad;
            end
            16'(RI_YRES): begin
                bad = locked || (wdata > MAX_Y);
                ok  = !bad;
            end
            16'(RI_BPP): begin
                norm = (wdata == 16'd0) ? 16'd8 : wdata;
                bad  = locked || !is_legal_bpp(norm);
                ok   = !bad;
            end
            16'(RI_ENA), 16'(RI_BANK), 16'(RI_VW),
            16'(RI_XOFF), 16'(RI_YOFF): ok = 1'b1;
            default: begin
                ok  = 1'b0;
                bad = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/disp_vheight.sv
module disp_vheight
    import disp_regfile_pkg::*;
#(
    parameter int unsigned VMEM_BYTES = 8388608
) (
    input  logic [15:0] width,
    input  logic [15:0] bpp,
    output logic [15:0] height
);
    localparam logic [31:0] NUM = 32'(VMEM_BYTES);

    logic [18:0] prod;
    logic [31:0] quot;

    always_comb begin
        prod = 19'(width) * 19'(bytes_pp(bpp));
        quot = (prod == 19'd0) ? 32'hFFFF_FFFF : NUM / {13'd0, prod};
        height = (quot > 32'h0000_FFFF) ? 16'hFFFF : quot[15:0];
    end
endmodule

// File: rtl/disp_regfile.sv
module disp_regfile
    import disp_regfile_pkg::*;
#(
    parameter logic [15:0] IDX_PORT   = 16'h01CE,
    parameter logic [15:0] DATA_PORT  = 16'h01CF,
    parameter logic [15:0] MAX_X      = 16'd1024,
    parameter logic [15:0] MAX_Y      = 16'd768,
    parameter logic [15:0] MAX_BPP    = 16'd32,
    parameter logic [15:0] ID_LO      = 16'hB0C0,
    parameter logic [15:0] ID_HI      = 16'hB0C4,
    parameter int unsigned VMEM_BYTES = 8388608
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic [15:0] io_wdata,
    output logic [15:0] io_rdata,
    output logic        err_pulse,
    output logic        clr_req,
    output logic        refresh_req,
    output logic        mode_en,
    output logic        lfb_en,
    output logic        dac8_en
);
    regs_t st_d, st_q;

    logic        wr_idx, wr_dat;
    logic        w_ok, w_bad;
    logic [15:0] w_norm;
    logic [15:0] calc_w, calc_h;

    assign wr_idx = io_wr && (io_addr == IDX_PORT);
    assign wr_dat = io_wr && (io_addr == DATA_PORT);

    disp_wcheck #(
        .MAX_X(MAX_X), .MAX_Y(MAX_Y), .ID_LO(ID_LO), .ID_HI(ID_HI)
    ) u_wcheck (
        .sel    (st_q.idx),
        .wdata  (io_wdata),
        .locked (st_q.ena[EN_BIT]),
        .ok     (w_ok),
        .bad    (w_bad),
        .norm   (w_norm)
    );

    // On enable the width comes from the stored resolution, otherwise from the bus
    assign calc_w = (st_q.idx == 16'(RI_ENA)) ? st_q.xres : io_wdata;

    disp_vheight #(.VMEM_BYTES(VMEM_BYTES)) u_vheight (
        .width  (calc_w),
        .bpp    (st_q.bpp),
        .height (calc_h)
    );

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        st_d.clr  = 1'b0;
        st_d.refr = 1'b0;
        if (wr_idx) st_d.idx = io_wdata;
        if (wr_dat) begin
            st_d.err = w_bad;
            if (w_ok) begin
                case (st_q.idx)
                    16'(RI_ID):   st_d.id   = w_norm;
                    16'(RI_XRES): st_d.xres = w_norm;
                    16'(RI_YRES): st_d.yres = w_norm;
                    16'(RI_BPP):  st_d.bpp  = w_norm;
                    16'(RI_ENA): begin
                        st_d.ena = io_wdata;
                        if (!st_q.ena[EN_BIT] && io_wdata[EN_BIT]) begin
                            st_d.vw  = st_q.xres;
                            st_d.vh  = calc_h;
                            st_d.clr = !io_wdata[KEEP_BIT];
                        end
                    end
                    16'(RI_BANK): st_d.bank = io_wdata;
                    16'(RI_VW): begin
                        st_d.vw = io_wdata;
                        if (st_q.ena[EN_BIT]) st_d.vh = calc_h;
                    end
                    16'(RI_XOFF): begin
                        st_d.xoff = io_wdata;
                        st_d.refr = 1'b1;
                    end
                    16'(RI_YOFF): begin
                        st_d.yoff = io_wdata;
                        st_d.refr = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.id <= ID_HI;
        end else begin
            st_q <= st_d;
        end
    end

    logic caps;
    assign caps = st_q.ena[CAPS_BIT];

    always_comb begin
        io_rdata = 16'd0;
        if (io_addr == IDX_PORT) begin
            io_rdata = st_q.idx;
        end else if (io_addr == DATA_PORT) begin
            case (st_q.idx)
                16'(RI_ID):   io_rdata = st_q.id;
                16'(RI_XRES): io_rdata = caps ? MAX_X : st_q.xres;
                16'(RI_YRES): io_rdata = caps ? MAX_Y : st_q.yres;
                16'(RI_BPP):  io_rdata = caps ? MAX_BPP : st_q.bpp;
                16'(RI_ENA):  io_rdata = st_q.ena;
                16'(RI_BANK): io_rdata = st_q.bank;
                16'(RI_VW):   io_rdata = st_q.vw;
                16'(RI_VH):   io_rdata = st_q.vh;
                16'(RI_XOFF): io_rdata = st_q.xoff;
                16'(RI_YOFF): io_rdata = st_q.yoff;
                default:      io_rdata = 16'd0;
            endcase
        end
    end

    assign err_pulse   = st_q.err;
    assign clr_req     = st_q.clr;
    assign refresh_req = st_q.refr;
    assign mode_en     = st_q.ena[EN_BIT];
    assign lfb_en      = st_q.ena[LFB_BIT];
    assign dac8_en     = st_q.ena[DAC_BIT];
endmodule

// File: rtl/disp_regfile_chk.sv
module disp_regfile_chk #(
    parameter logic [15:0] DATA_PORT = 16'h01CF,
    parameter logic [15:0] MAX_X     = 16'd1024,
    parameter logic [15:0] MAX_Y     = 16'd768,
    parameter logic [15:0] ID_LO     = 16'hB0C0,
    parameter logic [15:0] ID_HI     = 16'hB0C4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic [15:0] sel_idx,
    input logic        mode_en,
    input logic        err_pulse,
    input logic        clr_req,
    input logic        refresh_req,
    input logic [15:0] id_val,
    input logic [15:0] xres_val,
    input logic [15:0] yres_val,
    input logic [15:0] bpp_val
);
    logic dwr, locked_wr;
    assign dwr       = io_wr && (io_addr == DATA_PORT);
    assign locked_wr = dwr && mode_en &&
                       (sel_idx == 16'd1 || sel_idx == 16'd2 || sel_idx == 16'd3);

    AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_val >= ID_LO) && (id_val <= ID_HI)); // R2
    AST_LOCK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        locked_wr |=> err_pulse); // R3
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked_wr |=> ($stable(xres_val) && $stable(yres_val) && $stable(bpp_val))); // R3
    AST_RES_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (xres_val <= MAX_X) && (yres_val <= MAX_Y)); // R4
    AST_BPP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bpp_val == 16'd0 || bpp_val == 16'd8 || bpp_val == 16'd15 ||
        bpp_val == 16'd16 || bpp_val == 16'd24 || bpp_val == 16'd32); // R5
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !clr_req); // R6
    AST_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && (sel_idx == 16'd8 || sel_idx == 16'd9)) |=> refresh_req); // R10
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(dwr)); // R11
endmodule

bind disp_regfile disp_regfile_chk #(
    .DATA_PORT(DATA_PORT), .MAX_X(MAX_X), .MAX_Y(MAX_Y), .ID_LO(ID_LO), .ID_HI(ID_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .sel_idx     (st_q.idx),
    .mode_en     (mode_en),
    .err_pulse   (err_pulse),
    .clr_req     (clr_req),
    .refresh_req (refresh_req),
    .id_val      (st_q.id),
    .xres_val    (st_q.xres),
    .yres_val    (st_q.yres),
    .bpp_val     (st_q.bpp)
);

// File: tb/disp_regfile_bench.sv
module disp_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IPORT = 16'h01CE;
    localparam logic [15:0] DPORT = 16'h01CF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'd0;
    logic        io_wr = 1'b0;
    logic [15:0] io_wdata = 16'd0;
    logic [15:0] io_rdata;
    logic        err_pulse, clr_req, refresh_req, mode_en, lfb_en, dac8_en;

    int checks = 0;
    int errors = 0;
    logic p_err, p_clr, p_ref;

    always #(CLK_PERIOD / 2) clk = ~clk;

    disp_regfile u_disp_regfile (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .err_pulse(err_pulse),
        .clr_req(clr_req), .refresh_req(refresh_req), .mode_en(mode_en),
        .lfb_en(lfb_en), .dac8_en(dac8_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write is taken at the rising edge; pulses are captured at the next falling edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wr = 1'b1; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        p_err = err_pulse; p_clr = clr_req; p_ref = refresh_req;
    endtask

    task automatic wreg(input logic [15:0] i, input logic [15:0] d);
        wr(IPORT, i);
        wr(DPORT, d);
    endtask

    task automatic rreg(input logic [15:0] i, output logic [15:0] v);
        wr(IPORT, i);
        io_addr = DPORT;
        #1;
        v = io_rdata;
    endtask

    function automatic logic [15:0] vh_exp(input int x, input int b);
        int bpb, p, q;
        bpb = (b == 8) ? 1 : (b <= 16) ? 2 : (b == 24) ? 3 : 4;
        p = x * bpb;
        if (p == 0) return 16'hFFFF;
        q = 8388608 / p;
        return (q > 65535) ? 16'hFFFF : 16'(q);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] cur_bpp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state and index port (R1)
        rreg(16'd0, v); check("R1 reset id", v, 16'hB0C4);
        rreg(16'd1, v); check("R1 reset xres", v, 0);
        rreg(16'd7, v); check("R1 reset vheight", v, 0);
        check("R1 reset mode_en", mode_en, 0);
        wr(IPORT, 16'd3); io_addr = IPORT; #1; check("R1 index readback", io_rdata, 3);

        // Version range (R2)
        wreg(16'd0, 16'hB0C2); check("R2 legal id err", p_err, 0);
        rreg(16'd0, v); check("R2 legal id stored", v, 16'hB0C2);
        wreg(16'd0, 16'hB0C5); check("R2 high id err", p_err, 1);
        wreg(16'd0, 16'hB0BF); check("R2 low id err", p_err, 1);
        rreg(16'd0, v); check("R2 id kept", v, 16'hB0C2);
        wreg(16'd0, 16'hB0C0); check("R2 lower bound err", p_err, 0);

        // Resolution limits (R4)
        wreg(16'd1, 16'd1024); check("R4 xres 1024 err", p_err, 0);
        wreg(16'd1, 16'd1025); check("R4 xres 1025 err", p_err, 1);
        rreg(16'd1, v); check("R4 xres kept", v, 1024);
        wreg(16'd2, 16'd768); check("R4 yres 768 err", p_err, 0);
        wreg(16'd2, 16'd769); check("R4 yres 769 err", p_err, 1);
        rreg(16'd2, v); check("R4 yres kept", v, 768);

        // Error pulse length (R11)
        wreg(16'd2, 16'd900);
        @(negedge clk); check("R11 err drops", err_pulse, 0);

        // Depth sweep (R5)
        cur_bpp = 16'd0;
        for (int b = 0; b <= 40; b++) begin
            logic legal;
            legal = (b == 0 || b == 8 || b == 15 || b == 16 || b == 24 || b == 32);
            wreg(16'd3, 16'(b));
            check("R5 bpp err", p_err, !legal);
            if (legal) cur_bpp = (b == 0) ? 16'd8 : 16'(b);
            rreg(16'd3, v);
            check("R5 bpp value", v, cur_bpp);
        end

        // Enable with clear, geometry (R6, R7)
        wreg(16'd1, 16'd640);
        wreg(16'd3, 16'd8);
        wreg(16'd4, 16'h0001);
        check("R6 clr on enable", p_clr, 1);
        @(negedge clk); check("R6 clr one cycle", clr_req, 0);
        check("R6 mode_en", mode_en, 1);
        rreg(16'd6, v); check("R7 vw = xres", v, 640);
        rreg(16'd7, v); check("R7 vh", v, vh_exp(640, 8));

        // Locked writes (R3)
        wreg(16'd1, 16'd320); check("R3 xres locked err", p_err, 1);
        wreg(16'd2, 16'd200); check("R3 yres locked err", p_err, 1);
        wreg(16'd3, 16'd16);  check("R3 bpp locked err", p_err, 1);
        rreg(16'd1, v); check("R3 xres kept", v, 640);
        rreg(16'd3, v); check("R3 bpp kept", v, 8);

        // Capabilities (R9)
        wreg(16'd4, 16'h0003); check("R9 no clr without rise", p_clr, 0);
        rreg(16'd1, v); check("R9 caps xres", v, 1024);
        rreg(16'd2, v); check("R9 caps yres", v, 768);
        rreg(16'd3, v); check("R9 caps bpp", v, 32);
        wreg(16'd4, 16'h0001);
        rreg(16'd2, v); check("R9 caps off yres", v, 768);

        // Virtual width (R8)
        wreg(16'd6, 16'd2048);
        rreg(16'd7, v); check("R8 vh recompute", v, vh_exp(2048, 8));
        wreg(16'd7, 16'd5); check("R8 vh write no err", p_err, 0);
        rreg(16'd7, v); check("R8 vh write ignored", v, vh_exp(2048, 8));
        wreg(16'd4, 16'h0000);
        wreg(16'd6, 16'd100);
        rreg(16'd6, v); check("R8 vw stored disabled", v, 100);
        rreg(16'd7, v); check("R8 vh held disabled", v, vh_exp(2048, 8));

        // Flags, no clear with keep bit (R6)
        wreg(16'd4, 16'h00E1);
        check("R6 keep suppresses clr", p_clr, 0);
        check("R6 lfb_en", lfb_en, 1);
        check("R6 dac8_en", dac8_en, 1);
        wreg(16'd4, 16'h0000);
        check("R6 flags cleared", {mode_en, lfb_en, dac8_en}, 0);

        // Geometry sweep (R7)
        for (int i = 0; i < 6; i++) begin
            int xs;
            xs = (i == 0) ? 0 : (i == 1) ? 100 : (i == 2) ? 320 :
                 (i == 3) ? 640 : (i == 4) ? 800 : 1024;
            for (int j = 0; j < 5; j++) begin
                int bs;
                bs = (j == 0) ? 8 : (j == 1) ? 15 : (j == 2) ? 16 : (j == 3) ? 24 : 32;
                wreg(16'd4, 16'h0000);
                wreg(16'd1, 16'(xs));
                wreg(16'd3, 16'(bs));
                wreg(16'd4, 16'h0081);
                rreg(16'd7, v);
                check("R7 vh sweep", v, vh_exp(xs, bs));
            end
        end

        // Pan and bank (R10)
        wreg(16'd8, 16'd17); check("R10 xoff refresh", p_ref, 1);
        @(negedge clk); check("R10 refresh one cycle", refresh_req, 0);
        wreg(16'd9, 16'd33); check("R10 yoff refresh", p_ref, 1);
        wreg(16'd5, 16'd6); check("R10 bank no refresh", p_ref, 0);
        rreg(16'd5, v); check("R10 bank stored", v, 6);
        rreg(16'd8, v); check("R10 xoff stored", v, 17);
        rreg(16'd9, v); check("R10 yoff stored", v, 33);

        // Unknown index (R11)
        wreg(16'd12, 16'h1234); check("R11 unknown no err", p_err, 0);
        rreg(16'd12, v); check("R11 unknown reads 0", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule